// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block drives one leg of a cascaded H-bridge converter. It builds a set of stacked triangular carriers from one shared triangle counter, compares a signed reference sample against each carrier, and registers the resulting comparator pulses together with the switch gate signals that those pulses imply. With `NUM_LEVELS` output levels there are `NUM_LEVELS-1` carriers. Each carrier occupies its own vertical band of height `BAND_STEPS` reference units, and the bands touch but do not overlap, so the stack spans ±(NUM_LEVELS-1)/2·BAND_STEPS.

A two-bit disposition input chooses which carriers run with the triangle inverted, which means 180 degrees out of phase. All carriers can run together, neighbours can alternate, or the group above zero can oppose the group below zero. A configuration select chooses how the pulses become gate signals. In the equal-source arrangement each bridge cell takes a pair of mirrored carriers. In the unequal 1:2 source arrangement, available only for seven levels, two cells are driven by parity combinations of the pulses.

The triangle counter, the pulses and the gates advance only on cycles where the carrier tick input is high. Between ticks every output holds its value.

Top module: `lsmc_pwm_top`

## Requirements
- R1: While rst_n is low, every bit of pulses and gates is 0 and the triangle phase is 0. The first tick after reset therefore compares against a triangle value of 0.
- R2: The triangle counter has a phase that advances by one on each tick and wraps after 2·BAND_STEPS ticks. The triangle value equals the phase while the phase is below BAND_STEPS, and equals 2·BAND_STEPS minus the phase otherwise.
- R3: Pulse Pj is stored in pulses bit j-1, with P1 the uppermost carrier. Pj's carrier lies at (NC/2 − j)·BAND_STEPS + c, where NC = NUM_LEVELS−1 and c is either the triangle value t or BAND_STEPS − t. On a tick, Pj becomes 1 exactly when the signed refSample is strictly greater than that carrier.
- R4: dispMode 2'b00 (in phase), and also the unused code 2'b11, use c = t for every carrier.
- R5: dispMode 2'b01 (alternate opposition) uses c = BAND_STEPS − t for odd j and c = t for even j.
- R6: dispMode 2'b10 (opposition about zero) uses c = BAND_STEPS − t for carriers below zero (j > NC/2) and c = t for carriers above zero.
- R7: With asymSel = 0, cell i (i = 1..NC/2) owns gates bits 4(i−1)+3..4(i−1). Those four bits are, from low to high: P_i, not P_i, not P_(NC+1−i), P_(NC+1−i). Cell 1 therefore takes the outermost carriers.
- R8: With asymSel = 1 and seven levels, gates bit s−1 holds S_s. S1 = P1^P2^P3, S2 = not S1, S3 = P4^P5^P6, S4 = not S3, S5 = P2, S6 = not P2, S7 = P5, S8 = not P5. The remaining gate bits are 0. At other level counts asymSel is ignored.
- R9: pulses and gates are registered on the tick edge. Changes on refSample, dispMode or asymSel without a tick have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrierTick | input | 1 | Advance strobe for carriers and output registers |
| refSample | input | REF_W | Signed reference sample |
| dispMode | input | 2 | Carrier disposition select |
| asymSel | input | 1 | 1 selects the unequal-source gate mapping |
| pulses | output | NUM_LEVELS-1 | Registered comparator pulses, bit j-1 = Pj |
| gates | output | 2*(NUM_LEVELS-1) | Registered switch gate signals |

## Verification
The bench places references exactly on a carrier value and one step above it. A comparator written as greater-or-equal would flip a pulse on those samples. The bench also sweeps a full triangle period, including the turning points at 0 and BAND_STEPS, so a counter that holds an extra tick at a peak or that wraps early shows up as pulse edges landing one tick late. Each disposition is exercised with references in both the upper and the lower bands, so inverting the wrong group of carriers, or taking odd and even from the wrong end of the stack, changes specific pulses. Changing inputs between ticks catches an output that is not registered on the tick, and the parity gate mapping is compared bit by bit to catch a swapped pulse index.

// File: rtl/lsmc_pkg.sv
package lsmc_pkg;

  typedef enum logic [1:0] {
    DISP_INPHASE = 2'b00,
    DISP_ALTOPP  = 2'b01,
    DISP_OPPZERO = 2'b10,
    DISP_SPARE   = 2'b11
  } dispMode_e;

  typedef struct packed {
    logic load;
    logic selInPhase;
    logic selAltOpp;
    logic selOppZero;
  } lsmcStrobe_t;

endpackage

// File: rtl/lsmc_ctrl.sv
module lsmc_ctrl
  import lsmc_pkg::*;
#(
  parameter int BAND_STEPS = 16,
  parameter int PH_W       = $clog2(2 * BAND_STEPS),
  parameter int LVL_W      = $clog2(BAND_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrierTick,
  input  logic [1:0]        dispMode,
  output lsmcStrobe_t       strobe,
  output logic [LVL_W-1:0]  triLevel
);

  localparam logic [PH_W-1:0] PHASE_LAST = PH_W'(2 * BAND_STEPS - 1);
  localparam logic [PH_W:0]   TWO_BANDS  = (PH_W + 1)'(2 * BAND_STEPS);
  localparam logic [PH_W:0]   ONE_BAND   = (PH_W + 1)'(BAND_STEPS);

  logic [PH_W-1:0] phase;
  logic [PH_W:0]   phaseExt;
  logic [PH_W:0]   fallValue;
  dispMode_e       modeDec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (carrierTick) begin
      if (phase == PHASE_LAST) phase <= '0;
      else                     phase <= phase + 1'b1;
    end
  end

  always_comb begin
    phaseExt  = {1'b0, phase};
    fallValue = TWO_BANDS - phaseExt;
    if (phaseExt < ONE_BAND) triLevel = LVL_W'(phaseExt);
    else                     triLevel = LVL_W'(fallValue);
  end

  always_comb begin
    modeDec           = dispMode_e'(dispMode);
    strobe.load       = carrierTick;
    strobe.selAltOpp  = (modeDec == DISP_ALTOPP);
    strobe.selOppZero = (modeDec == DISP_OPPZERO);
    strobe.selInPhase = (modeDec == DISP_INPHASE) || (modeDec == DISP_SPARE);
  end

  AST_TRI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    triLevel <= LVL_W'(BAND_STEPS)); // R2

  AST_TRI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    carrierTick |=> ((LVL_W'(triLevel - $past(triLevel)) == LVL_W'(1)) ||
                     (LVL_W'($past(triLevel) - triLevel) == LVL_W'(1)))); // R2

  AST_TRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !carrierTick |=> $stable(triLevel)); // R9

endmodule

// File: rtl/lsmc_gatemap.sv
module lsmc_gatemap #(
  parameter int NUM_CARRIERS = 6,
  parameter int GATE_W       = 2 * NUM_CARRIERS
) (
  input  logic [NUM_CARRIERS-1:0] pulseVec,
  input  logic                    asymSel,
  output logic [GATE_W-1:0]       gateVec
);

  localparam int CELLS = NUM_CARRIERS / 2;

  logic [GATE_W-1:0] symGates;
  logic [GATE_W-1:0] asymGates;

  for (genvar cellIdx = 1; cellIdx <= CELLS; cellIdx++) begin : g_cell
    localparam int TOP_BIT = cellIdx - 1;
    localparam int LOW_BIT = NUM_CARRIERS - cellIdx;
    localparam int BASE    = 4 * (cellIdx - 1);
    assign symGates[BASE + 0] =  pulseVec[TOP_BIT];
    assign symGates[BASE + 1] = ~pulseVec[TOP_BIT];
    assign symGates[BASE + 2] = ~pulseVec[LOW_BIT];
    assign symGates[BASE + 3] =  pulseVec[LOW_BIT];
  end

  if (NUM_CARRIERS == 6) begin : g_asym
    logic upperParity;
    logic lowerParity;
    assign upperParity   = pulseVec[0] ^ pulseVec[1] ^ pulseVec[2];
    assign lowerParity   = pulseVec[3] ^ pulseVec[4] ^ pulseVec[5];
    assign asymGates[0]  =  upperParity;
    assign asymGates[1]  = ~upperParity;
    assign asymGates[2]  =  lowerParity;
    assign asymGates[3]  = ~lowerParity;
    assign asymGates[4]  =  pulseVec[1];
    assign asymGates[5]  = ~pulseVec[1];
    assign asymGates[6]  =  pulseVec[4];
    assign asymGates[7]  = ~pulseVec[4];
    assign asymGates[GATE_W-1:8] = '0;
    assign gateVec = asymSel ? asymGates : symGates;
  end else begin : g_symonly
    assign asymGates = symGates;
    assign gateVec   = asymGates;
    logic unusedSel;
    assign unusedSel = asymSel;
  end

endmodule

// File: rtl/lsmc_datapath.sv
module lsmc_datapath
  import lsmc_pkg::*;
#(
  parameter int NUM_CARRIERS = 6,
  parameter int BAND_STEPS   = 16,
  parameter int REF_W        = 8,
  parameter int LVL_W        = $clog2(BAND_STEPS + 1),
  parameter int GATE_W       = 2 * NUM_CARRIERS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  lsmcStrobe_t             strobe,
  input  logic [LVL_W-1:0]        triLevel,
  input  logic [REF_W-1:0]        refSample,
  input  logic                    asymSel,
  output logic [NUM_CARRIERS-1:0] pulses,
  output logic [GATE_W-1:0]       gates
);

  localparam int HALF = NUM_CARRIERS / 2;

  logic signed [31:0]      refExt;
  logic signed [31:0]      triRise;
  logic signed [31:0]      triFall;
  logic [NUM_CARRIERS-1:0] pulseNext;
  logic [GATE_W-1:0]       gateNext;

  assign refExt  = {{(32 - REF_W){refSample[REF_W-1]}}, refSample};
  assign triRise = {{(32 - LVL_W){1'b0}}, triLevel};
  assign triFall = 32'(BAND_STEPS) - triRise;

  for (genvar j = 1; j <= NUM_CARRIERS; j++) begin : g_carrier
    localparam int  BAND_BASE = (HALF - j) * BAND_STEPS;
    localparam bit  IS_ODD    = ((j % 2) == 1);
    localparam bit  IS_LOWER  = (j > HALF);
    logic               flipTri;
    logic signed [31:0] carrierVal;
    assign flipTri    = !strobe.selInPhase &&
                        ((strobe.selAltOpp && IS_ODD) || (strobe.selOppZero && IS_LOWER));
    assign carrierVal = 32'(BAND_BASE) + (flipTri ? triFall : triRise);
    assign pulseNext[j-1] = (refExt > carrierVal);
  end

  lsmc_gatemap #(
    .NUM_CARRIERS(NUM_CARRIERS),
    .GATE_W      (GATE_W)
  ) i_gatemap (
    .pulseVec(pulseNext),
    .asymSel (asymSel),
    .gateVec (gateNext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulses <= '0;
      gates  <= '0;
    end else if (strobe.load) begin
      pulses <= pulseNext;
      gates  <= gateNext;
    end
  end

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(pulses)); // R9

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> $stable(gates)); // R9

  AST_INPHASE_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.selInPhase) |=>
      ((pulses[NUM_CARRIERS-2:0] & ~pulses[NUM_CARRIERS-1:1]) == '0)); // R4

  AST_SYM_LEG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && !asymSel) |=> (gates[0] == pulses[0]) && (gates[3] == pulses[NUM_CARRIERS-1])); // R7

endmodule

// File: rtl/lsmc_pwm_top.sv
module lsmc_pwm_top
  import lsmc_pkg::*;
#(
  parameter int NUM_LEVELS = 7,
  parameter int BAND_STEPS = 16,
  parameter int REF_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      carrierTick,
  input  logic [REF_W-1:0]          refSample,
  input  logic [1:0]                dispMode,
  input  logic                      asymSel,
  output logic [NUM_LEVELS-2:0]     pulses,
  output logic [2*(NUM_LEVELS-1)-1:0] gates
);

  localparam int NUM_CARRIERS = NUM_LEVELS - 1;
  localparam int GATE_W       = 2 * NUM_CARRIERS;
  localparam int PH_W         = $clog2(2 * BAND_STEPS);
  localparam int LVL_W        = $clog2(BAND_STEPS + 1);

  lsmcStrobe_t      strobe;
  logic [LVL_W-1:0] triLevel;

  lsmc_ctrl #(
    .BAND_STEPS(BAND_STEPS),
    .PH_W      (PH_W),
    .LVL_W     (LVL_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrierTick(carrierTick),
    .dispMode   (dispMode),
    .strobe     (strobe),
    .triLevel   (triLevel)
  );

  lsmc_datapath #(
    .NUM_CARRIERS(NUM_CARRIERS),
    .BAND_STEPS  (BAND_STEPS),
    .REF_W       (REF_W),
    .LVL_W       (LVL_W),
    .GATE_W      (GATE_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .triLevel (triLevel),
    .refSample(refSample),
    .asymSel  (asymSel),
    .pulses   (pulses),
    .gates    (gates)
  );

  initial begin
    assert ((NUM_LEVELS % 2) == 1 && NUM_LEVELS >= 3)
      else $error("NUM_LEVELS must be odd and at least 3");
  end

endmodule

// File: tb/test_lsmc_pwm_top.sv
module test_lsmc_pwm_top;

  localparam int NUM_LEVELS = 7;
  localparam int BAND_STEPS = 16;
  localparam int REF_W      = 8;
  localparam int NC         = NUM_LEVELS - 1;
  localparam int GW         = 2 * NC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              carrierTick = 1'b0;
  logic [REF_W-1:0]  refSample = '0;
  logic [1:0]        dispMode = 2'b00;
  logic              asymSel = 1'b0;
  logic [NC-1:0]     pulses;
  logic [GW-1:0]     gates;

  int checks = 0;
  int fails  = 0;
  int benchPhase = 0;

  always #5 clk = ~clk;

  lsmc_pwm_top #(
    .NUM_LEVELS(NUM_LEVELS),
    .BAND_STEPS(BAND_STEPS),
    .REF_W     (REF_W)
  ) i_lsmc_pwm_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrierTick(carrierTick),
    .refSample  (refSample),
    .dispMode   (dispMode),
    .asymSel    (asymSel),
    .pulses     (pulses),
    .gates      (gates)
  );

  function automatic int triOf(int ph);
    return (ph < BAND_STEPS) ? ph : 2 * BAND_STEPS - ph;
  endfunction

  function automatic int carrierOf(int j, int ph, logic [1:0] m);
    int  t    = triOf(ph);
    bit  flip = 1'b0;
    if (m == 2'b01 && (j % 2) == 1) flip = 1'b1;
    if (m == 2'b10 && j > NC / 2)   flip = 1'b1;
    return (NC / 2 - j) * BAND_STEPS + (flip ? BAND_STEPS - t : t);
  endfunction

  function automatic logic [NC-1:0] expPulses(int r, int ph, logic [1:0] m);
    logic [NC-1:0] p;
    for (int j = 1; j <= NC; j++) p[j-1] = (r > carrierOf(j, ph, m));
    return p;
  endfunction

  function automatic logic [GW-1:0] expGates(logic [NC-1:0] p, logic a);
    logic [GW-1:0] g = '0;
    if (a) begin
      g[0] = p[0] ^ p[1] ^ p[2];
      g[1] = ~g[0];
      g[2] = p[3] ^ p[4] ^ p[5];
      g[3] = ~g[2];
      g[4] = p[1];
      g[5] = ~p[1];
      g[6] = p[4];
      g[7] = ~p[4];
    end else begin
      for (int i = 1; i <= NC / 2; i++) begin
        g[4*(i-1)+0] =  p[i-1];
        g[4*(i-1)+1] = ~p[i-1];
        g[4*(i-1)+2] = ~p[NC-i];
        g[4*(i-1)+3] =  p[NC-i];
      end
    end
    return g;
  endfunction

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic applyTick(int r, logic [1:0] m, logic a, string tag);
    logic [NC-1:0] ep;
    @(negedge clk);
    refSample   = REF_W'(r);
    dispMode    = m;
    asymSel     = a;
    carrierTick = 1'b1;
    ep = expPulses(r, benchPhase, m);
    @(negedge clk);
    carrierTick = 1'b0;
    checkVal({tag, " pulses"}, 32'(pulses), 32'(ep));
    checkVal(a ? "R8 gates" : "R7 gates", 32'(gates), 32'(expGates(ep, a)));
    benchPhase = (benchPhase + 1) % (2 * BAND_STEPS);
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R1 pulses in reset", 32'(pulses), 32'd0);
    checkVal("R1 gates in reset", 32'(gates), 32'd0);
    rst_n = 1'b1;
    benchPhase = 0;
    applyTick(0, 2'b00, 1'b0, "R1 first tick");
  endtask

  task automatic testInPhaseSweep();
    for (int k = 0; k < 2 * BAND_STEPS; k++) begin
      applyTick(-45 + 3 * k, 2'b00, 1'b0, "R2 R4 sweep");
    end
    applyTick(20, 2'b11, 1'b0, "R4 spare code");
    applyTick(-20, 2'b11, 1'b0, "R4 spare code");
  endtask

  task automatic testAltOpp();
    for (int k = 0; k < 12; k++) begin
      applyTick((k % 2 == 0) ? 7 * k : -7 * k, 2'b01, 1'b0, "R5 alternate");
    end
  endtask

  task automatic testOppZero();
    for (int k = 0; k < 12; k++) begin
      applyTick((k % 2 == 0) ? -40 + 5 * k : 40 - 5 * k, 2'b10, 1'b0, "R6 opposed");
    end
  endtask

  task automatic testBoundary();
    int c;
    c = carrierOf(3, benchPhase, 2'b00);
    applyTick(c, 2'b00, 1'b0, "R3 equal to carrier");
    c = carrierOf(2, benchPhase, 2'b00);
    applyTick(c + 1, 2'b00, 1'b0, "R3 one above carrier");
    applyTick(127, 2'b01, 1'b0, "R3 full positive");
    applyTick(-128, 2'b10, 1'b0, "R3 full negative");
  endtask

  task automatic testAsym();
    for (int k = 0; k < 15; k++) begin
      applyTick(-49 + 7 * k, 2'(k % 3), 1'b1, "R8 asym");
    end
  endtask

  task automatic testHold();
    logic [NC-1:0] heldP;
    logic [GW-1:0] heldG;
    applyTick(10, 2'b00, 1'b0, "R9 setup");
    heldP = pulses;
    heldG = gates;
    @(negedge clk);
    refSample = REF_W'(-100);
    dispMode  = 2'b10;
    asymSel   = 1'b1;
    repeat (4) @(negedge clk);
    checkVal("R9 pulses held", 32'(pulses), 32'(heldP));
    checkVal("R9 gates held", 32'(gates), 32'(heldG));
    applyTick(-5, 2'b00, 1'b0, "R9 after hold");
  endtask

  initial begin
    testReset();
    testInPhaseSweep();
    testAltOpp();
    testOppZero();
    testBoundary();
    testAsym();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule